// File: doc/BRIEF.md
# Debug Event Qualifier

This block sits behind the hardware address comparators of a processor's self-hosted debug logic. A comparator that has already matched an instruction or data address raises a hit strobe; the qualifier then decides whether that hit becomes a breakpoint or watchpoint event. It checks the comparator's own enable, the core's privilege level and security state, and an optional link to a context-aware breakpoint whose stored value must equal the current context ID. Two conditions gate everything: the global monitor-debug enable and the flag that says debug exceptions may be taken now.

Software loads the breakpoint control words, the breakpoint value words and the watchpoint control words through a single write port, one word per cycle. A write takes effect at the next clock edge. Hit strobes, core state and the resulting event pulses are plain control signals. There is no valid/ready handshake and no back-pressure. Each event is a one-cycle pulse with the index of the firing comparator, and it cannot be stalled.

Top module: `dbg_event_qualifier`

## Requirements
- R1: With `wr_en` high, `wr_sel` picks the target: 0 for a breakpoint control word, 1 for a breakpoint value word, 2 for a watchpoint control word, 3 for nothing. `wr_idx` picks the comparator. The word is used for qualification from the next cycle on.
- R2: When `mdbg_en` or `dbg_allow` is low, no hit of either kind produces an event.
- R3: A comparator whose control bit 0 (enable) is 0 never produces an event.
- R4: Control bit 1 allows a match at level 0 and control bit 2 allows a match at level 1. At level 2 or 3, a match needs control bit 13.
- R5: A watchpoint hit with its `wp_unpriv` bit set is qualified as if the core were at level 0. Breakpoints always use `cur_el`.
- R6: Control bits 15:14 select the security filter: 0 matches in either state, 2 matches only when `is_secure` is 1, and 1 or 3 match only when `is_secure` is 0. Watchpoints use the core's state as well.
- R7: When control bit 20 (link) is set, the comparator needs breakpoint number LBN (control bits 19:16) as its link target. LBN must satisfy B−C ≤ LBN ≤ B, where B is `feat_id[27:24]` and C is `feat_id[23:20]`, and it must name an implemented breakpoint. Otherwise the link fails and no event is produced.
- R8: A link target passes only if all of these hold: it is enabled, its type field (control bits 23:20) equals 3, `cur_el` is 0 or 1, and its value word equals `context_id`. Any other type, including 5, 9 and 11, fails the link.
- R9: When several comparators of one kind qualify in the same cycle, the lowest index is reported.
- R10: Events appear one clock after the qualifying hit. While its event is low, the index reads 0. A synchronous active-low reset clears the events, the indices and all stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target bank |
| wr_idx | input | 4 | Comparator index for the write |
| wr_data | input | 32 | Write data |
| cur_el | input | 2 | Current privilege level, 0 to 3 |
| is_secure | input | 1 | Core security state, 1 = secure |
| context_id | input | 32 | Current context ID |
| feat_id | input | 32 | Feature word carrying the breakpoint and context-aware counts |
| mdbg_en | input | 1 | Global monitor-debug enable |
| dbg_allow | input | 1 | Debug exceptions may be taken now |
| bp_hit | input | 6 | Per-breakpoint address hit strobes |
| wp_hit | input | 4 | Per-watchpoint address hit strobes |
| wp_unpriv | input | 4 | Watchpoint hit came from an unprivileged load or store |
| bp_evt | output | 1 | Breakpoint event pulse |
| bp_evt_idx | output | 3 | Index of the firing breakpoint |
| wp_evt | output | 1 | Watchpoint event pulse |
| wp_evt_idx | output | 2 | Index of the firing watchpoint |

## Verification
A wrong stored control or value word changes nothing until a hit reaches that comparator. It then shows one cycle later as a missing, extra or misnumbered event. A bad link target shows only on comparators that link to it, so the random mix sets link bits often and draws context values from a small set. A priority fault shows only when two qualified hits coincide. Directed vectors cover each filter edge, and random vectors with frequent reprogramming cover the combinations between them.

// File: rtl/dbg_qual_pkg.sv
package dbg_qual_pkg;

  typedef enum logic [1:0] {
    SEL_BP_CTRL = 2'd0,
    SEL_BP_VAL  = 2'd1,
    SEL_WP_CTRL = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;

  localparam logic [3:0] TYPE_CTX = 4'd3;

  // Qualification fields kept from a written control word.
  typedef struct packed {
    logic [3:0] typ;   // bits 23:20, bit 20 doubles as the link flag
    logic [3:0] lbn;   // bits 19:16
    logic [1:0] ssc;   // bits 15:14
    logic       hmc;   // bit 13
    logic [1:0] pac;   // bits 2:1
    logic       en;    // bit 0
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
    ctrl_t c;
    c.typ = w[23:20];
    c.lbn = w[19:16];
    c.ssc = w[15:14];
    c.hmc = w[13];
    c.pac = w[2:1];
    c.en  = w[0];
    return c;
  endfunction

endpackage

// File: rtl/dbg_cfg_bank.sv
module dbg_cfg_bank
  import dbg_qual_pkg::*;
#(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [3:0]               wr_idx,
  input  logic [31:0]              wr_data,
  output ctrl_t [NUM_BP-1:0]       bp_ctrl,
  output logic  [NUM_BP-1:0][31:0] bp_val,
  output ctrl_t [NUM_WP-1:0]       wp_ctrl
);

  ctrl_t wr_ctrl;
  assign wr_ctrl = unpack_ctrl(wr_data);

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[31:24], wr_data[12:3]};

  for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bp_ctrl[k] <= '0;
        bp_val[k]  <= '0;
      end else if (wr_en && wr_idx == 4'(k)) begin
        if (wr_sel == SEL_BP_CTRL) bp_ctrl[k] <= wr_ctrl;
        if (wr_sel == SEL_BP_VAL)  bp_val[k]  <= wr_data;
      end
    end

    AST_BP_VAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_BP_VAL && wr_idx == 4'(k)) |=> bp_val[k] == $past(wr_data)); // R1
  end

  for (genvar k = 0; k < NUM_WP; k++) begin : g_wp
    always_ff @(posedge clk) begin
      if (!rst_n)
        wp_ctrl[k] <= '0;
      else if (wr_en && wr_idx == 4'(k) && wr_sel == SEL_WP_CTRL)
        wp_ctrl[k] <= wr_ctrl;
    end

    AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_WP_CTRL && wr_idx == 4'(k)) |=> $stable(wp_ctrl[k])); // R1
  end

endmodule

// File: rtl/dbg_link_eval.sv
module dbg_link_eval
  import dbg_qual_pkg::*;
#(
  parameter int NUM_BP = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_t [NUM_BP-1:0]       bp_ctrl,
  input  logic  [NUM_BP-1:0][31:0] bp_val,
  input  logic  [31:0]             feat_id,
  input  logic  [1:0]              cur_el,
  input  logic  [31:0]             context_id,
  output logic  [NUM_BP-1:0]       ctx_ok
);

  logic [4:0] brps;
  logic [4:0] ctxc;
  assign brps = {1'b0, feat_id[27:24]};
  assign ctxc = {1'b0, feat_id[23:20]};

  logic unused_feat;
  assign unused_feat = ^{feat_id[31:28], feat_id[19:0]};

  logic low_el;
  assign low_el = (cur_el <= 2'd1);

  for (genvar n = 0; n < NUM_BP; n++) begin : g_tgt
    localparam logic [4:0] NN = 5'(n);
    logic in_range;
    logic unused_tgt;
    assign in_range   = (NN <= brps) && ((NN + ctxc) >= brps);
    assign unused_tgt = ^{bp_ctrl[n].lbn, bp_ctrl[n].ssc, bp_ctrl[n].hmc, bp_ctrl[n].pac};
    assign ctx_ok[n]  = in_range && bp_ctrl[n].en && (bp_ctrl[n].typ == TYPE_CTX)
                        && low_el && (bp_val[n] == context_id);
  end

  AST_CTX_HIGH_EL: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el > 2'd1) |-> (ctx_ok == '0)); // R8

endmodule

// File: rtl/dbg_cmp_qual.sv
module dbg_cmp_qual
  import dbg_qual_pkg::*;
#(
  parameter bit IS_WP  = 1'b0,
  parameter int NUM_BP = 6
) (
  input  ctrl_t             ctrl,
  input  logic              hit,
  input  logic              unpriv,
  input  logic [1:0]        cur_el,
  input  logic              is_secure,
  input  logic [NUM_BP-1:0] ctx_ok,
  output logic              qual
);

  logic [1:0] lvl;

  if (IS_WP) begin : g_wp_lvl
    assign lvl = unpriv ? 2'd0 : cur_el;
  end else begin : g_bp_lvl
    logic unused_up;
    assign unused_up = unpriv;
    assign lvl       = cur_el;
  end

  logic sec_ok, lvl_ok, link_ok;
  logic [15:0] ctx_ext;
  logic unused_typ;

  assign ctx_ext    = 16'(ctx_ok);
  assign unused_typ = ^ctrl.typ[3:1];

  always_comb begin
    unique case (ctrl.ssc)
      2'd0:    sec_ok = 1'b1;
      2'd2:    sec_ok = is_secure;
      default: sec_ok = !is_secure;
    endcase
    unique case (lvl)
      2'd0:    lvl_ok = ctrl.pac[0];
      2'd1:    lvl_ok = ctrl.pac[1];
      default: lvl_ok = ctrl.hmc;
    endcase
    link_ok = !ctrl.typ[0] || ctx_ext[ctrl.lbn];
  end

  assign qual = hit && ctrl.en && sec_ok && lvl_ok && link_ok;

endmodule

// File: rtl/dbg_low_pick.sv
module dbg_low_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/dbg_event_qualifier.sv
module dbg_event_qualifier
  import dbg_qual_pkg::*;
#(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 4,
  parameter int BPI_W  = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  parameter int WPI_W  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [3:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        cur_el,
  input  logic              is_secure,
  input  logic [31:0]       context_id,
  input  logic [31:0]       feat_id,
  input  logic              mdbg_en,
  input  logic              dbg_allow,
  input  logic [NUM_BP-1:0] bp_hit,
  input  logic [NUM_WP-1:0] wp_hit,
  input  logic [NUM_WP-1:0] wp_unpriv,
  output logic              bp_evt,
  output logic [BPI_W-1:0]  bp_evt_idx,
  output logic              wp_evt,
  output logic [WPI_W-1:0]  wp_evt_idx
);

  ctrl_t [NUM_BP-1:0]       bp_ctrl;
  logic  [NUM_BP-1:0][31:0] bp_val;
  ctrl_t [NUM_WP-1:0]       wp_ctrl;
  logic  [NUM_BP-1:0]       ctx_ok;
  logic  [NUM_BP-1:0]       bp_q;
  logic  [NUM_WP-1:0]       wp_q;
  logic                     bp_any, wp_any;
  logic  [BPI_W-1:0]        bp_pick;
  logic  [WPI_W-1:0]        wp_pick;

  dbg_cfg_bank #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .bp_ctrl(bp_ctrl), .bp_val(bp_val), .wp_ctrl(wp_ctrl)
  );

  dbg_link_eval #(.NUM_BP(NUM_BP)) u_link (
    .clk(clk), .rst_n(rst_n), .bp_ctrl(bp_ctrl), .bp_val(bp_val), .feat_id(feat_id),
    .cur_el(cur_el), .context_id(context_id), .ctx_ok(ctx_ok)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bpq
    dbg_cmp_qual #(.IS_WP(1'b0), .NUM_BP(NUM_BP)) u_q (
      .ctrl(bp_ctrl[i]), .hit(bp_hit[i]), .unpriv(1'b0), .cur_el(cur_el),
      .is_secure(is_secure), .ctx_ok(ctx_ok), .qual(bp_q[i])
    );
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wpq
    dbg_cmp_qual #(.IS_WP(1'b1), .NUM_BP(NUM_BP)) u_q (
      .ctrl(wp_ctrl[i]), .hit(wp_hit[i]), .unpriv(wp_unpriv[i]), .cur_el(cur_el),
      .is_secure(is_secure), .ctx_ok(ctx_ok), .qual(wp_q[i])
    );
  end

  dbg_low_pick #(.N(NUM_BP), .IW(BPI_W)) u_bp_pick (.req(bp_q), .any(bp_any), .idx(bp_pick));
  dbg_low_pick #(.N(NUM_WP), .IW(WPI_W)) u_wp_pick (.req(wp_q), .any(wp_any), .idx(wp_pick));

  logic gate;
  assign gate = mdbg_en && dbg_allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_evt     <= 1'b0;
      bp_evt_idx <= '0;
      wp_evt     <= 1'b0;
      wp_evt_idx <= '0;
    end else begin
      bp_evt     <= gate && bp_any;
      bp_evt_idx <= (gate && bp_any) ? bp_pick : '0;
      wp_evt     <= gate && wp_any;
      wp_evt_idx <= (gate && wp_any) ? wp_pick : '0;
    end
  end

  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(mdbg_en && dbg_allow) |=> (!bp_evt && !wp_evt)); // R2
  AST_BP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_hit == '0) |=> !bp_evt); // R10
  AST_WP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit == '0) |=> !wp_evt); // R10
  AST_BP_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_evt |-> (bp_evt_idx == '0)); // R10
  AST_WP_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_evt |-> (wp_evt_idx == '0)); // R10

endmodule

// File: tb/sim_dbg_event_qualifier.sv
module sim_dbg_event_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 6;
  localparam int NW = 4;

  localparam logic [31:0] EN   = 32'h1;
  localparam logic [31:0] PAC0 = 32'h2;
  localparam logic [31:0] PAC1 = 32'h4;
  localparam logic [31:0] HMC  = 32'h2000;
  localparam logic [31:0] LNK  = 32'h0010_0000;
  localparam logic [31:0] CTXA = 32'hA5A5_0001;
  localparam logic [31:0] CTXB = 32'h0000_7777;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [3:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic [1:0] cur_el = 0;
  logic is_secure = 0;
  logic [31:0] context_id = 0, feat_id = 0;
  logic mdbg_en = 0, dbg_allow = 0;
  logic [NB-1:0] bp_hit = 0;
  logic [NW-1:0] wp_hit = 0, wp_unpriv = 0;
  logic bp_evt, wp_evt;
  logic [2:0] bp_evt_idx;
  logic [1:0] wp_evt_idx;

  int checks = 0, fails = 0;
  logic [31:0] m_bpc [NB];
  logic [31:0] m_bpv [NB];
  logic [31:0] m_wpc [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_event_qualifier u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .cur_el(cur_el), .is_secure(is_secure), .context_id(context_id),
    .feat_id(feat_id), .mdbg_en(mdbg_en), .dbg_allow(dbg_allow), .bp_hit(bp_hit),
    .wp_hit(wp_hit), .wp_unpriv(wp_unpriv), .bp_evt(bp_evt), .bp_evt_idx(bp_evt_idx),
    .wp_evt(wp_evt), .wp_evt_idx(wp_evt_idx)
  );

  function automatic logic [31:0] ssc(int s);  return 32'(s) << 14; endfunction
  function automatic logic [31:0] lbn(int n);  return 32'(n) << 16; endfunction
  function automatic logic [31:0] typ(int t);  return 32'(t) << 20; endfunction

  function automatic bit m_link(int l);
    int b = int'(feat_id[27:24]);
    int c = int'(feat_id[23:20]);
    if (l > b || l < b - c || l >= NB) return 0;
    if (!m_bpc[l][0]) return 0;
    if (m_bpc[l][23:20] != 4'd3) return 0;
    if (cur_el > 2'd1) return 0;
    return m_bpv[l] == context_id;
  endfunction

  function automatic bit m_qual(logic [31:0] c, bit is_wp, bit up);
    int lvl = (is_wp && up) ? 0 : int'(cur_el);
    if (!c[0]) return 0;
    case (c[15:14])
      2'd0: ;
      2'd2: if (!is_secure) return 0;
      default: if (is_secure) return 0;
    endcase
    if (lvl == 0 && !c[1]) return 0;
    if (lvl == 1 && !c[2]) return 0;
    if (lvl >= 2 && !c[13]) return 0;
    if (c[20] && !m_link(int'(c[19:16]))) return 0;
    return 1;
  endfunction

  task automatic wr(int sel, int idx, logic [31:0] d);
    wr_en = 1; wr_sel = 2'(sel); wr_idx = 4'(idx); wr_data = d;
    bp_hit = 0; wp_hit = 0;
    if (sel == 0) m_bpc[idx] = d;
    if (sel == 1) m_bpv[idx] = d;
    if (sel == 2) m_wpc[idx] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // want: -1 no event, >=0 index, -2 take the model's answer
  task automatic vec(string req, int want_bp, int want_wp);
    int ebp = -1, ewp = -1, abp, awp;
    for (int i = NB - 1; i >= 0; i--)
      if (bp_hit[i] && m_qual(m_bpc[i], 0, 0)) ebp = i;
    for (int i = NW - 1; i >= 0; i--)
      if (wp_hit[i] && m_qual(m_wpc[i], 1, wp_unpriv[i])) ewp = i;
    if (!(mdbg_en && dbg_allow)) begin ebp = -1; ewp = -1; end
    if (want_bp != -2) ebp = want_bp;
    if (want_wp != -2) ewp = want_wp;
    @(negedge clk);
    abp = bp_evt ? int'(bp_evt_idx) : -1;
    awp = wp_evt ? int'(wp_evt_idx) : -1;
    checks++;
    if (abp != ebp || awp != ewp ||
        (!bp_evt && bp_evt_idx != 0) || (!wp_evt && wp_evt_idx != 0)) begin
      fails++;
      $display("FAIL %s: bp %0d (idx %0d) wp %0d (idx %0d), expected bp %0d wp %0d",
               req, abp, bp_evt_idx, awp, wp_evt_idx, ebp, ewp);
    end
  endtask

  task automatic hits(logic [NB-1:0] b, logic [NW-1:0] w, logic [NW-1:0] u);
    bp_hit = b; wp_hit = w; wp_unpriv = u;
  endtask

  function automatic logic [31:0] rnd_ctrl(bit is_bp);
    logic [31:0] c = $urandom;
    c[0] = ($urandom % 4) != 0;
    c[20] = ($urandom % 3) == 0;
    if (is_bp && ($urandom % 2) == 0) c[23:20] = 4'd3;
    if (is_bp && ($urandom % 6) == 0) c[23:20] = 4'd5;
    c[19:16] = 4'($urandom % 8);
    return c;
  endfunction

  task automatic reprogram();
    for (int i = 0; i < NB; i++) wr(0, i, rnd_ctrl(1));
    for (int i = 0; i < NB; i++) wr(1, i, ($urandom % 2) ? CTXA : CTXB);
    for (int i = 0; i < NW; i++) wr(2, i, rnd_ctrl(0));
    if ($urandom % 3 == 0) wr(3, $urandom % 8, $urandom);
  endtask

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) begin m_bpc[i] = 0; m_bpv[i] = 0; end
    for (int i = 0; i < NW; i++) m_wpc[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (bp_evt !== 1'b0 || wp_evt !== 1'b0 || bp_evt_idx !== 3'd0 || wp_evt_idx !== 2'd0) begin
      fails++;
      $display("FAIL R10 reset: bp %b/%0d wp %b/%0d, expected 0/0 0/0",
               bp_evt, bp_evt_idx, wp_evt, wp_evt_idx);
    end
    rst_n = 1;
    mdbg_en = 1; dbg_allow = 1; cur_el = 1; is_secure = 0;
    context_id = CTXA; feat_id = 32'h0520_0000;

    // R1 and R3: load, then disable
    wr(0, 0, EN | PAC0 | PAC1);
    hits(6'b000001, 0, 0); vec("R1 bp0 fires", 0, -1);
    hits(0, 0, 0);         vec("R10 no hit no event", -1, -1);
    wr(0, 0, PAC0 | PAC1);
    hits(6'b000001, 0, 0); vec("R3 disabled bp0", -1, -1);
    wr(0, 0, EN | PAC0 | PAC1);
    // R2 global gating
    mdbg_en = 0; hits(6'b000001, 0, 0); vec("R2 monitor enable low", -1, -1);
    mdbg_en = 1; dbg_allow = 0; vec("R2 debug not allowed", -1, -1);
    dbg_allow = 1;
    // R4 privilege
    wr(0, 0, 0);
    wr(0, 1, EN | PAC0);
    hits(6'b000010, 0, 0); vec("R4 level0-only at level1", -1, -1);
    cur_el = 0;            vec("R4 level0-only at level0", 1, -1);
    cur_el = 2;            vec("R4 level2 without higher-mode bit", -1, -1);
    wr(0, 1, EN | HMC);
    hits(6'b000010, 0, 0); vec("R4 level2 with higher-mode bit", 1, -1);
    cur_el = 1;
    // R5 unprivileged watchpoint access
    wr(0, 1, EN | PAC0);
    wr(2, 0, EN | PAC0);
    hits(0, 4'b0001, 4'b0001); vec("R5 unpriv wp as level0", -1, 0);
    hits(0, 4'b0001, 4'b0000); vec("R5 privileged wp at level1", -1, -1);
    hits(6'b000010, 0, 4'b1111); vec("R5 bp ignores unpriv", -1, -1);
    // R6 security
    wr(2, 1, EN | PAC1 | ssc(2));
    hits(0, 4'b0010, 0); vec("R6 secure-only in non-secure", -1, -1);
    is_secure = 1;       vec("R6 secure-only in secure", -1, 1);
    wr(2, 1, EN | PAC1 | ssc(3));
    hits(0, 4'b0010, 0); vec("R6 code 3 in secure", -1, -1);
    is_secure = 0;       vec("R6 code 3 in non-secure", -1, 1);
    // R7 link range
    wr(0, 4, EN | typ(3)); wr(1, 4, CTXA);
    wr(0, 2, EN | typ(3)); wr(1, 2, CTXA);
    wr(2, 2, EN | PAC1 | LNK | lbn(4));
    hits(0, 4'b0100, 0); vec("R7 linked in range", -1, 2);
    wr(2, 2, EN | PAC1 | LNK | lbn(2));
    hits(0, 4'b0100, 0); vec("R7 link below range", -1, -1);
    feat_id = 32'h0320_0000;
    wr(2, 2, EN | PAC1 | LNK | lbn(4));
    hits(0, 4'b0100, 0); vec("R7 link above range", -1, -1);
    feat_id = 32'h0520_0000;
    // R8 link target checks
    context_id = CTXB;   vec("R8 context mismatch", -1, -1);
    context_id = CTXA;
    wr(0, 4, EN | typ(5));
    hits(0, 4'b0100, 0); vec("R8 target type 5", -1, -1);
    wr(0, 4, typ(3));
    hits(0, 4'b0100, 0); vec("R8 target disabled", -1, -1);
    wr(0, 4, EN | typ(3));
    wr(2, 2, EN | PAC1 | HMC | LNK | lbn(4));
    cur_el = 2; hits(0, 4'b0100, 0); vec("R8 context match above level1", -1, -1);
    cur_el = 1;          vec("R8 context match at level1", -1, 2);
    // R9 priority
    wr(0, 0, EN | PAC0); wr(0, 1, EN | PAC1); wr(0, 3, EN | PAC1);
    wr(2, 0, EN | PAC1); wr(2, 3, EN | PAC1);
    hits(6'b001011, 4'b1001, 0); vec("R9 lowest qualified index", 1, 0);
    hits(0, 0, 0);               vec("R10 pulse lasts one cycle", -1, -1);

    // random mix
    for (int blk = 0; blk < 24; blk++) begin
      if (blk % 4 == 0) feat_id = {4'h0, 4'(3 + $urandom % 5), 4'($urandom % 5), 20'h0};
      reprogram();
      for (int v = 0; v < 25; v++) begin
        cur_el = 2'($urandom % 4);
        is_secure = 1'($urandom % 2);
        context_id = ($urandom % 3 == 0) ? CTXB : CTXA;
        mdbg_en = ($urandom % 10) != 0;
        dbg_allow = ($urandom % 10) != 0;
        hits(NB'($urandom), NW'($urandom), NW'($urandom));
        vec("R2 R4 R5 R6 R7 R8 R9 random", -2, -2);
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule